// File: doc/BRIEF.md
# Initial Bad Block Scanner

This block runs once after reset and finds the NAND blocks that left the factory marked as invalid. It walks through the device one block at a time, starting at block 0 and ending at the last block. For each block it asks a page-read port for a single byte: the marker byte in the spare area of the block's first page. It then records the block as good or bad in an internal bitmap. A read error on that port also marks the block bad, and the walk carries on.

While the walk is running, the bitmap can be read through a plain combinational address port. The block keeps a running count of good blocks. When the last block has been judged it raises a sticky done flag. If the final count is below the device minimum it also raises a device-fail flag.

A second address port returns an erase permit. The permit stays low for every block until the walk is finished, and after that it stays low for any block marked bad. Erase logic further down the chip therefore cannot touch a factory marker before it has been read.

The sequencer has three states:
- `ST_ISSUE` presents a request and moves to `ST_AWAIT` when `rd_req_ready` is high.
- `ST_AWAIT` waits for `rd_rsp_valid`. It then judges the block and either returns to `ST_ISSUE` for the next block or, after the last block, moves to `ST_FINISH`.
- `ST_FINISH` is terminal until reset.

Top module: `bad_block_scan`

## Requirements
- R1: After reset the outputs are as follows until the first response is accepted: `scan_done`=0, `valid_count`=0, `dev_fail`=0, every bitmap entry reads 0 and `ers_permit`=0.
- R2: Blocks are requested in ascending order from 0 to 2047. The request for block b carries page address b×32 and column 517, so the page address's low five bits are 0. At most one request is outstanding: `rd_req_valid` is low from the accepted handshake until the response has been consumed.
- R3: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted and `rd_page_addr` does not change.
- R4: A block other than block 0 is recorded bad (bitmap bit 1) when its returned byte differs from 8'hFF. It is recorded good (bitmap bit 0) when the byte equals 8'hFF and no error is flagged. The record is written at the clock edge that accepts the response.
- R5: A response with `rd_rsp_err`=1 marks the block bad whatever the data byte is, and the scan continues with the next block.
- R6: Block 0 is always recorded good and counted as valid, whatever byte or error is returned for it.
- R7: `valid_count` goes up by exactly one at the edge that accepts a good block's response, and does not change otherwise.
- R8: `scan_done` rises at the edge that accepts the response for block 2047. It then stays high until reset, and no further requests are issued.
- R9: `dev_fail` is 1 exactly when `scan_done`=1 and `valid_count` < 2008. A count of exactly 2008 does not fail.
- R10: `map_bad` shows the bitmap bit at `map_addr` combinationally, both during the scan and after it.
- R11: `ers_permit` is 1 only when `scan_done`=1 and the block at `ers_addr` is recorded good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the scan starts when it is released |
| rd_req_valid | output | 1 | A page-read request is presented |
| rd_req_ready | input | 1 | The page-read port accepts the request |
| rd_page_addr | output | 16 | Page address of the request (block × 32) |
| rd_col | output | 10 | Column of the requested byte (517) |
| rd_rsp_valid | input | 1 | The response byte is valid |
| rd_rsp_data | input | 8 | The byte that was read |
| rd_rsp_err | input | 1 | The read failed |
| map_addr | input | 11 | Block index for a bitmap read |
| map_bad | output | 1 | Bitmap entry at `map_addr` (1 = bad) |
| ers_addr | input | 11 | Block index for an erase-permit query |
| ers_permit | output | 1 | Erasing the block at `ers_addr` is allowed |
| scan_done | output | 1 | The scan is complete (sticky) |
| valid_count | output | 12 | Number of blocks recorded good |
| dev_fail | output | 1 | The scan is done and fewer than 2008 blocks are good |

## Verification
The scan is run three times, each after its own reset, and each run uses a different marker pattern:
- **Sparse pattern.** A few bad blocks, made in different ways: a byte one bit away from FFh, another non-FF byte, an error flag carrying an FFh byte, and a bad last block. A non-FF byte at block 0 is also included. This run separates "only FFh is good" from looser byte tests, checks that an error overrides the data, checks the block 0 exemption, and checks that the last block is judged.
- **2007 good blocks.** This must raise device-fail.
- **Exactly 2008 good blocks.** This must not raise it.

The second and third runs together pin down which side of the comparison the threshold sits on.

Throughout, the request port stalls and the response delay vary from block to block. This tests request hold, the one-outstanding rule and the page and column fields. A cycle-by-cycle model in the bench tracks the bitmap, the count and done, and is compared with the outputs at sliding map and erase addresses on every clock.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_ISSUE  = 2'd0,
        ST_AWAIT  = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int COL_W           = 10,
    parameter int MARK_COL        = 517,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int PG_SH  = $clog2(PAGES_PER_BLOCK),
    localparam int PAGE_W = BLK_W + PG_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PAGE_W-1:0] req_page,
    output logic [COL_W-1:0]  req_col,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    input  logic              rsp_err,
    output logic              wr_en,
    output logic [BLK_W-1:0]  wr_idx,
    output logic              wr_bad,
    output logic              scan_done
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [7:0]       ERASED   = 8'hFF;

    scan_state_e      state_q, state_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic             is_last;

    assign is_last = (blk_q == LAST_BLK);

    // next-state and block pointer
    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        unique case (state_q)
            ST_ISSUE: begin
                if (req_ready) begin
                    state_d = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (rsp_valid) begin
                    if (is_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_ISSUE;
                        blk_d   = blk_q + 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_FINISH;
            end
            default: begin
                state_d = ST_FINISH;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ISSUE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        wr_en     = 1'b0;
        wr_bad    = 1'b0;
        scan_done = 1'b0;
        req_page  = {blk_q, {PG_SH{1'b0}}};
        req_col   = COL_W'(MARK_COL);
        wr_idx    = blk_q;
        unique case (state_q)
            ST_ISSUE: begin
                req_valid = rst_n;
            end
            ST_AWAIT: begin
                wr_en  = rsp_valid;
                wr_bad = (blk_q != '0) && (rsp_err || (rsp_data != ERASED));
            end
            ST_FINISH: begin
                scan_done = 1'b1;
            end
            default: begin
                scan_done = 1'b0;
            end
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_page))); // R3

    AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> (scan_done && !req_valid)); // R8

endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic             scan_done,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad,
    input  logic [BLK_W-1:0] ers_idx,
    output logic             ers_ok
);

    logic [NUM_BLOCKS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_bad;
        end
    end

    always_comb begin
        rd_bad = bits_q[rd_idx];
        ers_ok = scan_done && !bits_q[ers_idx];
    end

    AST_BLK0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_q[0]); // R6

endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
    parameter int NUM_BLOCKS = 2048,
    parameter int MIN_VALID  = 2008,
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             scan_done,
    output logic [CNT_W-1:0] count,
    output logic             dev_fail
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        count    = count_q;
        dev_fail = scan_done && (count_q < CNT_W'(MIN_VALID));
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1)); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(NUM_BLOCKS)); // R7

endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int COL_W           = 10,
    parameter int MARK_COL        = 517,
    parameter int MIN_VALID       = 2008,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int PAGE_W = BLK_W + $clog2(PAGES_PER_BLOCK),
    localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [PAGE_W-1:0] rd_page_addr,
    output logic [COL_W-1:0]  rd_col,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    input  logic              rd_rsp_err,
    input  logic [BLK_W-1:0]  map_addr,
    output logic              map_bad,
    input  logic [BLK_W-1:0]  ers_addr,
    output logic              ers_permit,
    output logic              scan_done,
    output logic [CNT_W-1:0]  valid_count,
    output logic              dev_fail
);

    logic             wr_en;
    logic [BLK_W-1:0] wr_idx;
    logic             wr_bad;

    bbs_fsm #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .COL_W           (COL_W),
        .MARK_COL        (MARK_COL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (rd_req_valid),
        .req_ready (rd_req_ready),
        .req_page  (rd_page_addr),
        .req_col   (rd_col),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .rsp_err   (rd_rsp_err),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_bad    (wr_bad),
        .scan_done (scan_done)
    );

    bbs_bitmap #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_bad    (wr_bad),
        .scan_done (scan_done),
        .rd_idx    (map_addr),
        .rd_bad    (map_bad),
        .ers_idx   (ers_addr),
        .ers_ok    (ers_permit)
    );

    bbs_tally #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .MIN_VALID  (MIN_VALID)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (wr_en && !wr_bad),
        .scan_done (scan_done),
        .count     (valid_count),
        .dev_fail  (dev_fail)
    );

    AST_PERMIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ers_permit |-> scan_done); // R11

    AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_fail |-> scan_done); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done); // R8

endmodule

// File: tb/bad_block_scan_tb.sv
`timescale 1ns/1ps
module bad_block_scan_tb;

    localparam int NB = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [15:0] rd_page_addr;
    logic [9:0]  rd_col;
    logic        rd_rsp_valid = 1'b0;
    logic [7:0]  rd_rsp_data = 8'h00;
    logic        rd_rsp_err = 1'b0;
    logic [10:0] map_addr = '0;
    logic        map_bad;
    logic [10:0] ers_addr = '0;
    logic        ers_permit;
    logic        scan_done;
    logic [11:0] valid_count;
    logic        dev_fail;

    int checks = 0;
    int errors = 0;
    int run_id = 1;
    int resp_blk = 0;
    bit exp_bad [0:NB-1];
    int exp_cnt = 0;
    bit exp_done = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bad_block_scan u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_page_addr (rd_page_addr),
        .rd_col       (rd_col),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .rd_rsp_err   (rd_rsp_err),
        .map_addr     (map_addr),
        .map_bad      (map_bad),
        .ers_addr     (ers_addr),
        .ers_permit   (ers_permit),
        .scan_done    (scan_done),
        .valid_count  (valid_count),
        .dev_fail     (dev_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic void mark_of(input int run, input int b,
                                    output logic [7:0] d, output logic e);
        d = 8'hFF;
        e = 1'b0;
        case (run)
            1: begin
                if (b == 0)    d = 8'h00;
                if (b == 5)    d = 8'hFE;
                if (b == 9)    d = 8'hEF;
                if (b == 100)  e = 1'b1;
                if (b == 2047) d = 8'h7F;
            end
            2: begin
                if (b <= 41) d = 8'h00;
            end
            default: begin
                if (b >= 1 && b <= 40) begin
                    if (b % 2 == 1) e = 1'b1;
                    else            d = 8'h7F;
                end
            end
        endcase
    endfunction

    // page-read port responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_req_valid) begin
                logic [7:0] d;
                logic       e;
                chk(rd_page_addr == 16'(resp_blk * 32), "R2 page address", rd_page_addr, resp_blk * 32);
                chk(rd_col == 10'd517, "R2 column", rd_col, 517);
                for (int s = 0; s < resp_blk % 3; s++) begin
                    @(negedge clk);
                    chk(rd_req_valid && rd_page_addr == 16'(resp_blk * 32), "R3 request hold",
                        rd_page_addr, resp_blk * 32);
                end
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                for (int l = 0; l < resp_blk % 4; l++) begin
                    chk(!rd_req_valid, "R2 one outstanding", rd_req_valid, 0);
                    @(negedge clk);
                end
                chk(!rd_req_valid, "R2 one outstanding", rd_req_valid, 0);
                mark_of(run_id, resp_blk, d, e);
                rd_rsp_data  = d;
                rd_rsp_err   = e;
                rd_rsp_valid = 1'b1;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_err   = 1'b0;
                resp_blk++;
            end
        end
    end

    // reference model: response consumed at the edge it is presented
    always @(posedge clk) begin
        if (rst_n && rd_rsp_valid && resp_blk < NB) begin
            bit bad;
            bad = (resp_blk != 0) && (rd_rsp_err || rd_rsp_data != 8'hFF);
            exp_bad[resp_blk] = bad;
            if (!bad) exp_cnt++;
            if (resp_blk == NB - 1) exp_done = 1'b1;
        end
    end

    // per-cycle comparison
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && !finished) begin
                chk(scan_done == exp_done, "R8 done", scan_done, exp_done);
                chk(valid_count == 12'(exp_cnt), "R7 count", valid_count, exp_cnt);
                chk(dev_fail == (exp_done && exp_cnt < 2008), "R9 dev_fail", dev_fail,
                    int'(exp_done && exp_cnt < 2008));
                chk(map_bad == exp_bad[map_addr], exp_done ? "R4 bitmap" : "R10 bitmap mid-scan",
                    map_bad, exp_bad[map_addr]);
                chk(ers_permit == (exp_done && !exp_bad[ers_addr]), "R11 erase permit",
                    ers_permit, int'(exp_done && !exp_bad[ers_addr]));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", scan_done, 1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        resp_blk = 0;
        exp_cnt = 0;
        exp_done = 1'b0;
        for (int i = 0; i < NB; i++) exp_bad[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scan_done, "R1 reset done", scan_done, 0);
        chk(valid_count == 0, "R1 reset count", valid_count, 0);
        chk(!dev_fail, "R1 reset dev_fail", dev_fail, 0);
        for (int i = 0; i < NB; i++) begin
            map_addr = 11'(i);
            ers_addr = 11'(i);
            #1;
            chk(!map_bad, "R1 reset bitmap", map_bad, 0);
            chk(!ers_permit, "R1 reset permit", ers_permit, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_scan();
        int guard;
        guard = 0;
        while (!exp_done && guard < 60000) begin
            @(negedge clk);
            map_addr = map_addr + 11'd37;
            ers_addr = ers_addr + 11'd53;
            guard++;
        end
        @(negedge clk);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            map_addr = 11'(i);
            ers_addr = 11'(NB - 1 - i);
        end
        @(negedge clk);
    endtask

    task automatic probe(input int b, input bit bad, input string tag);
        @(negedge clk);
        map_addr = 11'(b);
        ers_addr = 11'(b);
        #1;
        chk(map_bad == bad, tag, map_bad, bad);
        chk(ers_permit == !bad, {tag, " R11 permit"}, ers_permit, !bad);
    endtask

    initial begin
        run_id = 1;
        do_reset();
        run_scan();
        probe(0, 1'b0, "R6 block 0 forced good");
        probe(5, 1'b1, "R4 byte FE is bad");
        probe(9, 1'b1, "R4 byte EF is bad");
        probe(100, 1'b1, "R5 error marks bad");
        probe(101, 1'b0, "R5 scan continues after error");
        probe(2047, 1'b1, "R8 last block judged");
        chk(valid_count == 12'd2044, "R7 final count run 1", valid_count, 2044);
        chk(!dev_fail, "R9 no fail run 1", dev_fail, 0);
        repeat (5) @(negedge clk);
        chk(scan_done && !rd_req_valid, "R8 sticky done, no request", rd_req_valid, 0);

        run_id = 2;
        do_reset();
        run_scan();
        probe(0, 1'b0, "R6 block 0 forced good run 2");
        chk(valid_count == 12'd2007, "R7 final count run 2", valid_count, 2007);
        chk(dev_fail, "R9 fail at 2007", dev_fail, 1);

        run_id = 3;
        do_reset();
        run_scan();
        probe(1, 1'b1, "R5 error with FF byte");
        probe(2, 1'b1, "R4 byte 7F is bad");
        probe(41, 1'b0, "R4 byte FF is good");
        chk(valid_count == 12'd2008, "R7 final count run 3", valid_count, 2008);
        chk(!dev_fail, "R9 no fail at exactly 2008", dev_fail, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule